// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block stores incoming Ethernet frames in system memory. It uses a ring of descriptors that software keeps in memory. Each descriptor is four consecutive 32-bit words:

| Offset | Word |
|--------|------|
| +0 | status |
| +4 | control and buffer size |
| +8 | data buffer address |
| +12 | link address |

The engine reads the descriptor at its current pointer and keeps a copy. When the first byte of a frame arrives, the engine checks the ownership flag in the status word.

- If the engine owns the descriptor, it packs the frame bytes into little-endian words and writes them to the data buffer. It then writes back a status word that holds the stored length and hands the descriptor back to software. After that it moves to the next descriptor and reads it straight away.
- If software owns the descriptor, the frame is lost. The engine raises a buffer-unavailable event and stays suspended until software asks it to look again.

Software uses the block through a few register-level inputs: a list base address with a load strobe, a poll-demand strobe, a write-one-to-clear event register, and an interrupt mask. A missed-frame counter reports lost frames. The memory side is a single word port with byte enables, and read data returns one cycle after the request. The frame input is a byte stream with first and last flags and no back-pressure. A new frame therefore needs roughly eight idle cycles after the previous frame's last byte. This gap lets the engine write back status and read the next descriptor.

Top module: `rx_ring_dma`

## Requirements
- R1: A descriptor read fetches four words at pointer+0, +4, +8 and +12, always as word-aligned reads. The engine uses these fields:
  - status bit 31: engine owns the descriptor;
  - control bits 10:0: buffer size in bytes;
  - control bit 25: end of ring;
  - control bit 24: follow the link;
  - word 2: buffer address, with its low two bits ignored;
  - word 3: link address.
- R2: Frame byte n goes to buffer address + n, with byte n%4 in bits 8*(n%4)+7:8*(n%4) of its word. Writes carry byte enables for the written lanes only. No byte at or beyond the buffer size is written.
- R3: After the last data write, the engine writes a status word to the descriptor with these fields:
  - bit 31 = 0;
  - bits 26:16 = number of bytes stored;
  - bit 0 = 1 if the frame was truncated;
  - every other bit = 0.
- R4: After a write-back, the next pointer is chosen in this priority order:
  - if the end-of-ring bit is set, the current list base;
  - else if the link bit is set, the link address;
  - else pointer + 16.
- R5: A frame longer than the buffer size keeps only its first size bytes. Its stored length equals the buffer size, and status bit 0 is set.
- R6: A frame that starts while the held descriptor is owned by software has the following effects:
  - it writes nothing to memory;
  - it adds one to the missed counter;
  - it sets event bit 7;
  - it suspends the engine, so later frames are also lost even after software sets the ownership bit in memory.
- R7: A poll-demand pulse, while the engine is waiting or suspended, re-reads the descriptor at the current pointer, so a newly armed descriptor is then used.
- R8: A frame that starts while the engine is stopped or busy is lost without any memory write. This covers descriptor read, data flush and write-back. The missed counter adds one, and event bit 7 is not set.
- R9: The missed-frame counter is MISS_W bits wide, counts up by one per lost frame, and saturates at all ones.
- R10: Event bit 6 is set for every stored frame and bit 7 on entering suspension. Each event bit stays set until a write with a 1 in that bit position on the clear input. Bits other than 7 and 6 always read 0.
- R11: The interrupt output is high exactly when some event bit is set whose mask bit is also set.
- R12: After reset the engine is stopped and makes no memory access until a base load. A base load always updates the list base. It moves the pointer to the base and reads that descriptor only when the engine is stopped, waiting or suspended.
- R13: During and after reset the event register, interrupt and missed counter are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_base | input | AW | Receive list base address |
| rx_base_ld | input | 1 | Load strobe for rx_base |
| rx_poll | input | 1 | Poll-demand strobe |
| rx_valid | input | 1 | Frame byte present |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_last | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| sts | output | 8 | Event register |
| sts_clr | input | 8 | Write-one-to-clear strobe for sts |
| irq_mask | input | 8 | Interrupt mask, same layout as sts |
| irq | output | 1 | Interrupt request |
| missed | output | MISS_W | Missed-frame counter |

## Verification
A wrong ring pointer does not show in the data buffer. It shows in the status word of the next stored frame, which is written to the wrong descriptor about two cycles after that frame's last byte. The bench therefore checks every write-back location against a pointer it tracks independently. A byte-lane or count fault in the packer corrupts buffer contents or the length field at the same write-back. A stale held descriptor or a missing suspension appears as a frame that is stored when it should have been counted as missed, or counted when it should have been stored.

// File: rtl/rxr_pkg.sv
// Shared field positions and engine state encoding for the receive ring DMA.
// Assumes 32-bit descriptor words and byte-addressed memory.
package rxr_pkg;
    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 4;
    localparam int OWN_BIT     = 31;
    localparam int LEN_LSB     = 16;
    localparam int LEN_W       = 11;
    localparam int EOR_BIT     = 25;
    localparam int LINK_BIT    = 24;
    localparam int TRUNC_BIT   = 0;
    localparam int STS_W       = 8;
    localparam int STS_DONE    = 6;
    localparam int STS_UNAVAIL = 7;

    typedef enum logic [2:0] {
        S_STOP,
        S_FETCH,
        S_READY,
        S_SUSP,
        S_RECV,
        S_FLUSH,
        S_WBACK
    } eng_state_t;
endpackage

// File: rtl/rxr_packer.sv
// Packs accepted frame bytes into little-endian words for the data buffer.
// Assumes at most one byte per cycle, so a packed word is written out the
// cycle after it completes and the memory port is then free. Bytes at or past
// the buffer size are discarded and flagged as truncation.
module rxr_packer
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_en,
    input  logic             last,
    input  logic [7:0]       byte_in,
    input  logic [LEN_W-1:0] buf_size,
    input  logic [AW-1:0]    buf_addr,
    output logic             wr_pend,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic [3:0]       wr_be,
    output logic [LEN_W-1:0] byte_cnt,
    output logic             trunc
);
    logic [LEN_W-1:0] eff_cnt;
    logic [1:0]       lane;
    logic             fits;
    logic [AW-1:0]    word_addr;

    // Byte position of the incoming byte and whether it still fits the buffer.
    always_comb begin
        eff_cnt   = start ? '0 : byte_cnt;
        lane      = eff_cnt[1:0];
        fits      = eff_cnt < buf_size;
        word_addr = {buf_addr[AW-1:2], 2'b00} + AW'({eff_cnt[LEN_W-1:2], 2'b00});
    end

    // Accumulate bytes into the current word and raise a one-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend  <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_be    <= '0;
            byte_cnt <= '0;
            trunc    <= 1'b0;
        end else begin
            wr_pend <= 1'b0;
            if (byte_en) begin
                if (start) begin
                    trunc <= 1'b0;
                end
                if (fits) begin
                    wr_data  <= ((lane == 2'd0) ? 32'h0 : wr_data) | (32'(byte_in) << (8 * lane));
                    wr_be    <= ((lane == 2'd0) ? 4'h0 : wr_be) | (4'b0001 << lane);
                    wr_addr  <= word_addr;
                    byte_cnt <= eff_cnt + 1'b1;
                    wr_pend  <= (lane == 2'd3) || last || ((eff_cnt + 1'b1) == buf_size);
                end else begin
                    byte_cnt <= eff_cnt;
                    trunc    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxr_status.sv
// Event register with write-one-to-clear, interrupt masking and a saturating
// missed-frame counter. A set and a clear in the same cycle leave the bit set.
module rxr_status
    import rxr_pkg::*;
#(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_done,
    input  logic              ev_unavail,
    input  logic              ev_miss,
    input  logic [STS_W-1:0]  clr,
    input  logic [STS_W-1:0]  mask,
    output logic [STS_W-1:0]  sts,
    output logic              irq,
    output logic [MISS_W-1:0] missed
);
    logic [STS_W-1:0] set_v;

    // Map engine events onto their event bit positions.
    always_comb begin
        set_v              = '0;
        set_v[STS_DONE]    = ev_done;
        set_v[STS_UNAVAIL] = ev_unavail;
    end

    // Event register: clear by writing ones, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr) | set_v;
        end
    end

    // Missed-frame counter, stops at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed <= '0;
        end else if (ev_miss && (missed != {MISS_W{1'b1}})) begin
            missed <= missed + 1'b1;
        end
    end

    assign irq = |(sts & mask);
endmodule

// File: rtl/rxr_ctrl.sv
// Ring walker: holds the current descriptor pointer, reads descriptors,
// decides per frame whether to store or drop it, writes back the status word
// and selects the next descriptor. Assumes read data arrives one cycle after
// a read request and that frames are well formed (first ... last).
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base_in,
    input  logic             base_ld,
    input  logic             poll,
    input  logic             rx_valid,
    input  logic             rx_first,
    input  logic             rx_last,
    input  logic [31:0]      mem_rdata,
    input  logic [LEN_W-1:0] pk_cnt,
    input  logic             pk_trunc,
    output logic             c_req,
    output logic             c_we,
    output logic [AW-1:0]    c_addr,
    output logic [31:0]      c_wdata,
    output logic [LEN_W-1:0] buf_size,
    output logic [AW-1:0]    buf_addr,
    output logic             pk_start,
    output logic             pk_byte_en,
    output logic             ev_done,
    output logic             ev_unavail,
    output logic             ev_miss
);
    localparam int FCNT_W = $clog2(DESC_WORDS + 1);

    eng_state_t        state;
    logic [AW-1:0]     cur_ptr;
    logic [AW-1:0]     base_q;
    logic [FCNT_W-1:0] fcnt;
    logic [31:0]       desc_q [DESC_WORDS];

    logic          own;
    logic          frame_start;
    logic          take;
    logic          idle;
    logic [AW-1:0] nxt_ptr;
    logic [31:0]   wb_word;
    logic [1:0]    cap_idx;

    // Frame admission and event decode from the held descriptor.
    always_comb begin
        own         = desc_q[0][OWN_BIT];
        frame_start = rx_valid && rx_first;
        take        = frame_start && (state == S_READY) && own;
        pk_start    = take;
        pk_byte_en  = take || ((state == S_RECV) && rx_valid);
        ev_miss     = frame_start && !take && (state != S_RECV);
        ev_unavail  = frame_start && (state == S_READY) && !own;
        ev_done     = (state == S_WBACK);
        idle        = (state == S_STOP) || (state == S_READY) || (state == S_SUSP);
        buf_size    = desc_q[1][LEN_W-1:0];
        buf_addr    = desc_q[2][AW-1:0];
        cap_idx     = fcnt[1:0] - 2'd1;
    end

    // Next descriptor: end of ring beats link, link beats sequential.
    always_comb begin
        if (desc_q[1][EOR_BIT]) begin
            nxt_ptr = base_q;
        end else if (desc_q[1][LINK_BIT]) begin
            nxt_ptr = {desc_q[3][AW-1:2], 2'b00};
        end else begin
            nxt_ptr = cur_ptr + AW'(DESC_WORDS * 4);
        end
    end

    // Status word handed back to software.
    always_comb begin
        wb_word                        = '0;
        wb_word[LEN_LSB +: LEN_W]      = pk_cnt;
        wb_word[TRUNC_BIT]             = pk_trunc;
    end

    // Memory requests issued by the ring walker.
    always_comb begin
        c_req   = 1'b0;
        c_we    = 1'b0;
        c_addr  = cur_ptr;
        c_wdata = '0;
        if ((state == S_FETCH) && (fcnt < FCNT_W'(DESC_WORDS))) begin
            c_req  = 1'b1;
            c_addr = cur_ptr + AW'({fcnt, 2'b00});
        end else if (state == S_WBACK) begin
            c_req   = 1'b1;
            c_we    = 1'b1;
            c_wdata = wb_word;
        end
    end

    // Engine sequencing, pointer and descriptor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_STOP;
            cur_ptr <= '0;
            base_q  <= '0;
            fcnt    <= '0;
            for (int i = 0; i < DESC_WORDS; i++) begin
                desc_q[i] <= '0;
            end
        end else begin
            if (base_ld) begin
                base_q <= base_in;
            end
            case (state)
                S_FETCH: begin
                    fcnt <= fcnt + 1'b1;
                    if (fcnt != '0) begin
                        desc_q[cap_idx] <= mem_rdata;
                    end
                    if (fcnt == FCNT_W'(DESC_WORDS)) begin
                        state <= S_READY;
                    end
                end
                S_RECV: begin
                    if (rx_valid && rx_last) begin
                        state <= S_FLUSH;
                    end
                end
                S_FLUSH: begin
                    state <= S_WBACK;
                end
                S_WBACK: begin
                    cur_ptr <= nxt_ptr;
                    fcnt    <= '0;
                    state   <= S_FETCH;
                end
                default: begin
                    if (take) begin
                        state <= rx_last ? S_FLUSH : S_RECV;
                    end else if (frame_start && (state == S_READY)) begin
                        state <= S_SUSP;
                    end else if (idle && base_ld) begin
                        cur_ptr <= base_in;
                        fcnt    <= '0;
                        state   <= S_FETCH;
                    end else if (poll && (state != S_STOP)) begin
                        fcnt  <= '0;
                        state <= S_FETCH;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_dma.sv
// Top of the receive descriptor ring DMA engine. Joins the ring walker, the
// byte packer and the event block, and shares the single memory port: a
// pending packed word always goes first, which never collides because the
// walker only accesses memory while no frame data is in flight.
module rx_ring_dma
    import rxr_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rx_base,
    input  logic              rx_base_ld,
    input  logic              rx_poll,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_last,
    input  logic [7:0]        rx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [STS_W-1:0]  sts,
    input  logic [STS_W-1:0]  sts_clr,
    input  logic [STS_W-1:0]  irq_mask,
    output logic              irq,
    output logic [MISS_W-1:0] missed
);
    logic             c_req, c_we;
    logic [AW-1:0]    c_addr;
    logic [31:0]      c_wdata;
    logic [LEN_W-1:0] buf_size;
    logic [AW-1:0]    buf_addr;
    logic             pk_start, pk_byte_en;
    logic             ev_done, ev_unavail, ev_miss;
    logic             pk_pend;
    logic [AW-1:0]    pk_addr;
    logic [31:0]      pk_data;
    logic [3:0]       pk_be;
    logic [LEN_W-1:0] pk_cnt;
    logic             pk_trunc;

    rxr_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_in    (rx_base),
        .base_ld    (rx_base_ld),
        .poll       (rx_poll),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .rx_last    (rx_last),
        .mem_rdata  (mem_rdata),
        .pk_cnt     (pk_cnt),
        .pk_trunc   (pk_trunc),
        .c_req      (c_req),
        .c_we       (c_we),
        .c_addr     (c_addr),
        .c_wdata    (c_wdata),
        .buf_size   (buf_size),
        .buf_addr   (buf_addr),
        .pk_start   (pk_start),
        .pk_byte_en (pk_byte_en),
        .ev_done    (ev_done),
        .ev_unavail (ev_unavail),
        .ev_miss    (ev_miss)
    );

    rxr_packer #(.AW(AW)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pk_start),
        .byte_en  (pk_byte_en),
        .last     (rx_last),
        .byte_in  (rx_data),
        .buf_size (buf_size),
        .buf_addr (buf_addr),
        .wr_pend  (pk_pend),
        .wr_addr  (pk_addr),
        .wr_data  (pk_data),
        .wr_be    (pk_be),
        .byte_cnt (pk_cnt),
        .trunc    (pk_trunc)
    );

    rxr_status #(.MISS_W(MISS_W)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_done    (ev_done),
        .ev_unavail (ev_unavail),
        .ev_miss    (ev_miss),
        .clr        (sts_clr),
        .mask       (irq_mask),
        .sts        (sts),
        .irq        (irq),
        .missed     (missed)
    );

    // Memory port sharing: packed frame data first, then the walker.
    always_comb begin
        if (pk_pend) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = pk_addr;
            mem_be    = pk_be;
            mem_wdata = pk_data;
        end else begin
            mem_req   = c_req;
            mem_we    = c_we;
            mem_addr  = c_addr;
            mem_be    = 4'hF;
            mem_wdata = c_wdata;
        end
    end
endmodule

// File: rtl/rx_ring_dma_chk.sv
// Port-level temporal checks for the receive ring DMA, bound to the top.
module rx_ring_dma_chk #(
    parameter int AW     = 32,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_base_ld,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [3:0]        mem_be,
    input logic [7:0]        sts,
    input logic              irq,
    input logic [MISS_W-1:0] missed
);
    logic seen_ld;

    // Remembers whether a base load has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_ld <= 1'b0;
        end else if (rx_base_ld) begin
            seen_ld <= 1'b1;
        end
    end

    // R12
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_ld |-> !mem_req);

    // R1
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));

    // R2
    wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    // R10
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[6]) |-> $past(mem_req && mem_we));

    // R9
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(missed) |-> (missed == $past(missed) + 1'b1));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == 8'h00) |-> !irq);
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW), .MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_base_ld (rx_base_ld),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .sts        (sts),
    .irq        (irq),
    .missed     (missed)
);

// File: tb/rx_ring_dma_test.sv
// Self-checking bench: sweeps frame length against buffer size around a
// three-descriptor ring and exercises drop, suspend, poll and reload paths.
module rx_ring_dma_test;
    localparam int AW     = 32;
    localparam int MISS_W = 16;
    localparam logic [31:0] D0 = 32'h100;
    localparam logic [31:0] D1 = 32'h200;
    localparam logic [31:0] D2 = 32'h210;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     rx_base = '0;
    logic              rx_base_ld = 1'b0;
    logic              rx_poll = 1'b0;
    logic              rx_valid = 1'b0;
    logic              rx_first = 1'b0;
    logic              rx_last = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              mem_req, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic [7:0]        sts;
    logic [7:0]        sts_clr = '0;
    logic [7:0]        irq_mask = 8'h40;
    logic              irq;
    logic [MISS_W-1:0] missed;

    logic [31:0] mem [256];
    int checks = 0;
    int errors = 0;
    logic [31:0] exp_ptr;
    logic [31:0] base_now;

    always #4 clk = ~clk;

    rx_ring_dma #(.AW(AW), .MISS_W(MISS_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_base(rx_base), .rx_base_ld(rx_base_ld),
        .rx_poll(rx_poll), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_last(rx_last), .rx_data(rx_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sts(sts), .sts_clr(sts_clr), .irq_mask(irq_mask),
        .irq(irq), .missed(missed)
    );

    // Memory model: one-cycle read latency, byte-enabled writes.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int tag, input int i);
        return 8'((tag * 37) + (i * 5) + 1);
    endfunction

    function automatic logic [31:0] buf_of(input logic [31:0] p);
        if (p == D0) return 32'h300;
        if (p == D1) return 32'h342;  // low bits ignored: word 0x340
        return 32'h380;
    endfunction

    function automatic logic [31:0] ctl_of(input logic [31:0] p);
        if (p == D0) return 32'hFDC0_0000;  // link bit set
        if (p == D1) return 32'h0000_0000;  // sequential
        return 32'hFFC0_0000;               // end of ring beats link
    endfunction

    function automatic logic [31:0] link_of(input logic [31:0] p);
        if (p == D0) return D1;
        if (p == D1) return 32'h3F0;
        return D1;
    endfunction

    function automatic logic [31:0] next_of(input logic [31:0] p);
        if (p == D0) return D1;
        if (p == D1) return D2;
        return base_now;
    endfunction

    task automatic arm(input logic [31:0] p, input int size, input bit own);
        mem[p[9:2]]        = own ? 32'h8000_0000 : 32'h0;
        mem[p[9:2] + 8'd1] = ctl_of(p) | 32'(size);
        mem[p[9:2] + 8'd2] = buf_of(p);
        mem[p[9:2] + 8'd3] = link_of(p);
        for (int w = 0; w < 16; w++) mem[buf_of(p) >> 2 & 32'hFF | 32'(w)] = 32'hA5A5_A5A5;
    endtask

    task automatic poll_pulse();
        @(negedge clk) rx_poll = 1'b1;
        @(negedge clk) rx_poll = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic put_frame(input int n, input int tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_first = (i == 0);
            rx_last  = (i == n - 1);
            rx_data  = byte_val(tag, i);
        end
    endtask

    task automatic quiet_in();
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
    endtask

    task automatic clear_sts(input logic [7:0] bits);
        @(negedge clk) sts_clr = bits;
        @(negedge clk) sts_clr = 8'h00;
    endtask

    // Verify buffer bytes (R2/R5) and write-back word (R3/R4) at exp_ptr.
    task automatic check_store(input int len, input int size, input int tag);
        int kept;
        logic [7:0] got, want;
        bit ok;
        logic [31:0] wexp;
        kept = (len < size) ? len : size;
        ok = 1'b1;
        got = '0; want = '0;
        for (int k = 0; k < 64; k++) begin
            logic [7:0] g;
            g = mem[(32'h0 | buf_of(exp_ptr)) >> 2 & 32'hFC | 32'(k / 4)][8*(k%4) +: 8];
            if (k < kept) begin
                if (g != byte_val(tag, k) && ok) begin ok = 1'b0; got = g; want = byte_val(tag, k); end
            end else begin
                if (g != 8'hA5 && ok) begin ok = 1'b0; got = g; want = 8'hA5; end
            end
        end
        check(ok, (len > size) ? "R5" : "R2", "buffer byte", 32'(got), 32'(want));
        wexp = {1'b0, 4'b0, 11'(kept), 15'b0, (len > size)};
        check(mem[exp_ptr[9:2]] == wexp, "R3", "status word", mem[exp_ptr[9:2]], wexp);
    endtask

    task automatic frame_test(input int len, input int size, input int tag);
        arm(exp_ptr, size, 1'b1);
        poll_pulse();
        put_frame(len, tag);
        quiet_in();
        for (int k = 0; k < 40 && !sts[6]; k++) @(negedge clk);
        check(sts[6] == 1'b1, "R10", "done event", 32'(sts), 32'h40);
        check(irq == 1'b1, "R11", "irq with done unmasked", 32'(irq), 32'h1);
        check_store(len, size, tag);
        clear_sts(8'h40);
        check(sts == 8'h00 && irq == 1'b0, "R10", "w1c clear", 32'(sts), 32'h0);
        exp_ptr = next_of(exp_ptr);
        repeat (8) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int m0;
        bit quiet;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        // R13 reset state
        check(sts == 8'h00 && irq == 1'b0 && missed == '0, "R13", "reset state",
              {sts, 7'b0, irq, missed}, 32'h0);
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req) quiet = 1'b0;
        end
        check(quiet, "R12", "no access while stopped", 32'(!quiet), 32'h0);
        // R8 frame while stopped
        put_frame(2, 99);
        quiet_in();
        @(negedge clk);
        check(missed == 16'd1 && sts[7] == 1'b0, "R8", "miss while stopped", 32'(missed), 32'h1);

        base_now = D0;
        exp_ptr  = D0;
        @(negedge clk) begin rx_base = D0; rx_base_ld = 1'b1; end
        @(negedge clk) rx_base_ld = 1'b0;
        repeat (8) @(negedge clk);

        // R1 R2 R4 R5 sweep: lengths against two buffer sizes around the ring
        for (int s = 0; s < 2; s++) begin
            for (int len = 1; len <= 12; len++) begin
                frame_test(len, (s == 0) ? 5 : 8, len + 16 * s);
            end
        end

        // R8 frame starting during flush is lost
        arm(exp_ptr, 8, 1'b1);
        poll_pulse();
        m0 = int'(missed);
        put_frame(4, 50);
        put_frame(1, 51);
        quiet_in();
        repeat (3) @(negedge clk);
        check(int'(missed) == m0 + 1 && sts[7] == 1'b0, "R8", "miss while busy", 32'(missed), 32'(m0 + 1));
        check_store(4, 8, 50);
        clear_sts(8'h40);
        exp_ptr = next_of(exp_ptr);
        repeat (8) @(negedge clk);

        // R6 descriptor owned by software
        arm(exp_ptr, 8, 1'b0);
        poll_pulse();
        m0 = int'(missed);
        put_frame(3, 60);
        quiet_in();
        @(negedge clk);
        check(int'(missed) == m0 + 1 && sts == 8'h80, "R6", "unowned drop", {sts, 8'h0, missed}, {8'h80, 8'h0, 16'(m0 + 1)});
        check(irq == 1'b0, "R11", "irq masked", 32'(irq), 32'h0);
        irq_mask = 8'hC0;
        @(negedge clk);
        check(irq == 1'b1, "R11", "irq unmasked", 32'(irq), 32'h1);
        irq_mask = 8'h40;
        check(mem[exp_ptr[9:2]] == 32'h0 && mem[buf_of(exp_ptr) >> 2 & 32'hFC] == 32'hA5A5_A5A5,
              "R6", "no write on drop", mem[exp_ptr[9:2]], 32'h0);
        clear_sts(8'h80);
        mem[exp_ptr[9:2]] = 32'h8000_0000;
        put_frame(3, 61);
        quiet_in();
        repeat (4) @(negedge clk);
        check(int'(missed) == m0 + 2 && sts[6] == 1'b0, "R6", "stays suspended", 32'(missed), 32'(m0 + 2));
        check(mem[exp_ptr[9:2]] == 32'h8000_0000, "R6", "descriptor untouched", mem[exp_ptr[9:2]], 32'h8000_0000);
        // R7 poll makes the armed descriptor usable
        frame_test(7, 8, 62);

        // R12 base reload while waiting, R4 end-of-ring returns to new base
        @(negedge clk) begin rx_base = D2; rx_base_ld = 1'b1; end
        @(negedge clk) rx_base_ld = 1'b0;
        repeat (8) @(negedge clk);
        base_now = D2;
        exp_ptr  = D2;
        frame_test(6, 8, 70);
        check(exp_ptr == D2, "R4", "wrap target", exp_ptr, D2);
        frame_test(9, 8, 71);

        // R9 saturation of the missed counter
        arm(exp_ptr, 8, 1'b0);
        poll_pulse();
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = 1'b1; rx_last = 1'b1; rx_data = 8'h11;
        end
        quiet_in();
        @(negedge clk);
        check(missed == 16'hFFFF, "R9", "saturated count", 32'(missed), 32'hFFFF);
        put_frame(1, 80);
        quiet_in();
        @(negedge clk);
        check(missed == 16'hFFFF, "R9", "count holds at max", 32'(missed), 32'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule